// File: doc/BRIEF.md
# Multi-Channel Tamper Timestamp Capture

This block watches up to four active-low tamper inputs. When an enabled channel sees its input fall, it copies the present calendar time into that channel's timestamp bank, raises the channel's flag, and, if that channel's interrupt is enabled, drives an active-low interrupt line. Each input first passes through a two-flop synchronizer. A capture starts on a falling edge of the synchronized level, not on the low level itself.

Software reaches the block through a byte-wide register port with a combinational read path. One status register holds the packed flags and one register holds the interrupt enables. Each channel also has its own seven-byte bank. The first byte of a bank is a control byte with two working bits: a disable bit and a capture-mode bit. In first-event mode the stored time is frozen until software clears the flag. In last-event mode every new event overwrites the stored time.

Each channel runs a three-state machine. CH_OFF is idle, disabled, with no flag. CH_ARMED is enabled, with no flag. CH_HELD means the flag is set. The transitions are:
- CH_OFF goes to CH_ARMED when the disable bit is clear.
- CH_ARMED goes to CH_OFF when the disable bit is set.
- CH_OFF or CH_ARMED goes to CH_HELD on an accepted edge, with a capture.
- CH_HELD goes back to CH_OFF or CH_ARMED on a flag clear with no accepted edge in the same cycle.
- CH_HELD stays in CH_HELD with a capture on an accepted edge, in last-event mode or when a clear arrives in the same cycle.
- CH_HELD stays in CH_HELD without a capture on an accepted edge in first-event mode.

Top module: `tamper_capture`

## Requirements
- R1: After reset all of the following are zero: the status register (address 0x00), the enable register (address 0x01), every control byte and every timestamp byte. irq_n is high.
- R2: A falling edge on an enabled channel's input stores the time in its bank within three clock edges. Bank n (0-based) starts at address 0x10+8n. Its byte order is: control, seconds, minutes, hours, day, month, year. Each field is zero-extended to a byte (7, 7, 6, 6, 5 and 8 bits). The edge also sets the channel's flag, at status bit 7-n.
- R3: With control bit 7 clear, events that arrive while the flag is set leave the stored time unchanged.
- R4: With control bit 7 set, every accepted event overwrites the stored time.
- R5: With control bit 6 set, an event neither captures nor sets the flag. After the bit is cleared, events are accepted again.
- R6: Writing 0 to a status flag bit clears that flag. Writing 1 leaves it as it is. After a clear, the next event captures even in first-event mode. An event in the same cycle as a clear wins.
- R7: irq_n is low exactly when some channel has both its flag and its enable set. The enable for channel n is bit 7-n of address 0x01.
- R8: Timestamp bytes are read-only, so writes to them are ignored. Control bits 5..0 always read 0.
- R9: An input that stays low produces exactly one capture. A later change of the time while the input is still low is not stored.
- R10: Unmapped addresses, including byte 7 of each bank, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_n | input | NCH | Active-low tamper inputs, asynchronous |
| t_sec | input | 7 | Current seconds, BCD |
| t_min | input | 7 | Current minutes, BCD |
| t_hour | input | 6 | Current hours, BCD |
| t_day | input | 6 | Current day of month, BCD |
| t_month | input | 5 | Current month 1..12, BCD |
| t_year | input | 8 | Current year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a channel already in CH_HELD that receives a second accepted edge. What must happen then depends on the mode bit, and the input must have risen and fallen again across the synchronizer. The stimulus first sets a distinct time and lets one event land. It then changes the time and pulses the same input again, once in each mode. A separate run holds the input low while the time changes, which separates a true edge detector from a level detector.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
    localparam int MAX_CH      = 4;
    localparam int REG_STATUS  = 0;
    localparam int REG_IEN     = 1;
    localparam int BANK_BASE   = 16;
    localparam int BANK_SPAN   = 8;
    localparam int FLAG_TOP    = 7;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] day;
        logic [5:0] hour;
        logic [6:0] minute;
        logic [6:0] second;
    } stamp_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_HELD  = 2'd2
    } ch_state_e;

    function automatic logic [7:0] bank_byte(input stamp_t s, input logic mode,
                                             input logic dis, input int unsigned idx);
        logic [7:0] b;
        b = 8'h00;
        case (idx)
            0: b = {mode, dis, 6'b0};
            1: b = {1'b0, s.second};
            2: b = {1'b0, s.minute};
            3: b = {2'b0, s.hour};
            4: b = {2'b0, s.day};
            5: b = {3'b0, s.month};
            6: b = s.year;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[DEPTH-2:0], pin_n};
        end
    end

    // previous synchronized level high, current low
    assign fall = shift_q[DEPTH-1] & ~shift_q[DEPTH-2];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9
endmodule

// File: rtl/tsc_channel.sv
`timescale 1ns/1ps
module tsc_channel
    import tsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall,
    input  logic   ctrl_we,
    input  logic   ctrl_mode_wd,
    input  logic   ctrl_dis_wd,
    input  logic   clr,
    input  stamp_t now,
    output logic   flag,
    output logic   mode,
    output logic   dis,
    output stamp_t stamp
);
    ch_state_e st_q, st_d;
    logic      mode_q, dis_q;
    stamp_t    stamp_q;
    logic      accept;
    logic      cap;

    assign accept = fall & ~dis_q;

    // next state and capture strobe
    always_comb begin
        st_d = st_q;
        cap  = 1'b0;
        unique case (st_q)
            CH_OFF: begin
                if (accept) begin
                    cap  = 1'b1;
                    st_d = CH_HELD;
                end else if (!dis_q) begin
                    st_d = CH_ARMED;
                end
            end
            CH_ARMED: begin
                if (accept) begin
                    cap  = 1'b1;
                    st_d = CH_HELD;
                end else if (dis_q) begin
                    st_d = CH_OFF;
                end
            end
            CH_HELD: begin
                if (accept && (mode_q || clr)) begin
                    cap  = 1'b1;
                end else if (clr && !accept) begin
                    st_d = dis_q ? CH_OFF : CH_ARMED;
                end
            end
            default: st_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // control and stamp storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            dis_q   <= 1'b0;
            stamp_q <= '0;
        end else begin
            if (ctrl_we) begin
                mode_q <= ctrl_mode_wd;
                dis_q  <= ctrl_dis_wd;
            end
            if (cap) begin
                stamp_q <= now;
            end
        end
    end

    // outputs
    always_comb begin
        flag  = (st_q == CH_HELD);
        mode  = mode_q;
        dis   = dis_q;
        stamp = stamp_q;
    end

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !dis_q) |=> flag); // R2

    AST_FIRST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !mode_q && !clr) |=> $stable(stamp_q)); // R3

    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !flag) |=> !flag); // R5

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !fall) |=> !flag); // R6
endmodule

// File: rtl/tsc_regs.sv
`timescale 1ns/1ps
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NCH-1:0]    flags,
    input  logic [NCH-1:0]    modes,
    input  logic [NCH-1:0]    diss,
    input  stamp_t            stamps [NCH],
    output logic [NCH-1:0]    ctrl_we,
    output logic [NCH-1:0]    clr,
    output logic              irq_n
);
    logic [NCH-1:0] ien_q;
    logic           hit_status, hit_ien;

    assign hit_status = (addr == ADDR_W'(REG_STATUS));
    assign hit_ien    = (addr == ADDR_W'(REG_IEN));

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_dec
            assign ctrl_we[g] = wr && (addr == ADDR_W'(BANK_BASE + g * BANK_SPAN));
            assign clr[g]     = wr && hit_status && !wdata[FLAG_TOP - g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr && hit_ien) begin
            for (int c = 0; c < NCH; c++) begin
                ien_q[c] <= wdata[FLAG_TOP - c];
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit_status) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[FLAG_TOP - c] = flags[c];
            end
        end else if (hit_ien) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[FLAG_TOP - c] = ien_q[c];
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < BANK_SPAN; b++) begin
                    if (addr == ADDR_W'(BANK_BASE + c * BANK_SPAN + b)) begin
                        rdata = bank_byte(stamps[c], modes[c], diss[c], b);
                    end
                end
            end
        end
    end

    assign irq_n = ~|(flags & ien_q);

    AST_IEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ien && (wdata[7:4] == 4'h0)) |=> irq_n); // R7
endmodule

// File: rtl/tamper_capture.sv
`timescale 1ns/1ps
module tamper_capture
    import tsc_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tamper_n,
    input  logic [6:0]        t_sec,
    input  logic [6:0]        t_min,
    input  logic [5:0]        t_hour,
    input  logic [5:0]        t_day,
    input  logic [4:0]        t_month,
    input  logic [7:0]        t_year,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n
);
    localparam int LAST_ADDR = BANK_BASE + NCH * BANK_SPAN - 1;

    stamp_t         now;
    stamp_t         stamps [NCH];
    logic [NCH-1:0] falls, flags, modes, diss, ctrl_we, clr;

    always_comb begin
        now.second = t_sec;
        now.minute = t_min;
        now.hour   = t_hour;
        now.day    = t_day;
        now.month  = t_month;
        now.year   = t_year;
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_n (tamper_n[g]),
                .fall  (falls[g])
            );
            tsc_channel u_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .fall         (falls[g]),
                .ctrl_we      (ctrl_we[g]),
                .ctrl_mode_wd (reg_wdata[7]),
                .ctrl_dis_wd  (reg_wdata[6]),
                .clr          (clr[g]),
                .now          (now),
                .flag         (flags[g]),
                .mode         (modes[g]),
                .dis          (diss[g]),
                .stamp        (stamps[g])
            );
        end
    endgenerate

    tsc_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .flags   (flags),
        .modes   (modes),
        .diss    (diss),
        .stamps  (stamps),
        .ctrl_we (ctrl_we),
        .clr     (clr),
        .irq_n   (irq_n)
    );

    initial begin
        AST_MAP_FITS: assert (LAST_ADDR < (1 << ADDR_W) && NCH <= MAX_CH); // R10
    end

    AST_CLEAR_ALL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(REG_STATUS) && reg_wdata[7:4] == 4'h0 && falls == '0)
        |=> irq_n); // R7
endmodule

// File: tb/sim_tamper_capture.sv
`timescale 1ns/1ps
module sim_tamper_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tamper_n = 4'hF;
    logic [7:0] cur [6];
    logic [6:0] t_sec = '0, t_min = '0;
    logic [5:0] t_hour = '0, t_day = '0;
    logic [4:0] t_month = '0;
    logic [7:0] t_year = '0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    int   q_kind [$];
    logic [7:0] q_exp [$];
    string q_tag [$];

    logic [7:0] m_stamp [4][6];
    logic [7:0] m_ctrl [4];
    logic       m_flag [4];

    always #2.5 clk = ~clk;

    tamper_capture u0 (
        .clk(clk), .rst_n(rst_n), .tamper_n(tamper_n),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_day(t_day),
        .t_month(t_month), .t_year(t_year),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // monitor: pops one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                int k; logic [7:0] e, a; string t;
                k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
                a = (k == 1) ? {7'b0, irq_n} : reg_rdata;
                n_vec++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", t, a, e);
                end
            end
        end
    end

    task automatic rd_chk(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(posedge clk); #1;
        q_kind.push_back(1); q_exp.push_back({7'b0, e}); q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
        @(posedge clk); #1;
        cur[0] = s; cur[1] = mi; cur[2] = h; cur[3] = d; cur[4] = mo; cur[5] = y;
        t_sec = s[6:0]; t_min = mi[6:0]; t_hour = h[5:0];
        t_day = d[5:0]; t_month = mo[4:0]; t_year = y;
    endtask

    // expected effect of an event, from the requirements
    task automatic model_event(input int ch);
        if (!m_ctrl[ch][6]) begin
            if (!m_flag[ch] || m_ctrl[ch][7]) begin
                for (int i = 0; i < 6; i++) m_stamp[ch][i] = cur[i];
            end
            m_flag[ch] = 1'b1;
        end
    endtask

    task automatic pulse(input int ch);
        @(posedge clk); #1; tamper_n[ch] = 1'b0;
        repeat (4) @(posedge clk);
        #1; tamper_n[ch] = 1'b1;
        repeat (4) @(posedge clk);
        model_event(ch);
    endtask

    task automatic chk_bank(input int ch, input string tag);
        rd_chk(6'(16 + ch * 8), m_ctrl[ch] & 8'hC0, {tag, " ctrl"});
        for (int i = 0; i < 6; i++) begin
            rd_chk(6'(16 + ch * 8 + i + 1), m_stamp[ch][i], $sformatf("%s byte%0d", tag, i + 1));
        end
    endtask

    function automatic logic [7:0] status_exp();
        logic [7:0] v = 8'h00;
        for (int c = 0; c < 4; c++) v[7 - c] = m_flag[c];
        return v;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_ctrl[c] = 8'h00; m_flag[c] = 1'b0;
            for (int i = 0; i < 6; i++) m_stamp[c][i] = 8'h00;
        end
        for (int i = 0; i < 6; i++) cur[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(6'h00, 8'h00, "R1 status");
        rd_chk(6'h01, 8'h00, "R1 enable");
        for (int c = 0; c < 4; c++) chk_bank(c, $sformatf("R1 bank%0d", c));
        irq_chk(1'b1, "R1 irq_n");

        // R2 first capture on channel 0
        set_time(8'h59, 8'h30, 8'h23, 8'h31, 8'h12, 8'h99);
        pulse(0);
        rd_chk(6'h00, status_exp(), "R2 status flag ch0");
        chk_bank(0, "R2 bank0");
        irq_chk(1'b1, "R7 irq masked");

        // R3 first-event mode keeps the earlier time
        set_time(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06);
        pulse(0);
        chk_bank(0, "R3 bank0");

        // R4 last-event mode overwrites
        wr(6'h18, 8'h80); m_ctrl[1] = 8'h80;
        pulse(1);
        set_time(8'h45, 8'h12, 8'h08, 8'h15, 8'h07, 8'h24);
        pulse(1);
        chk_bank(1, "R4 bank1");
        rd_chk(6'h00, status_exp(), "R4 status");

        // R5 disabled channel ignores events
        wr(6'h20, 8'h40); m_ctrl[2] = 8'h40;
        pulse(2);
        rd_chk(6'h00, status_exp(), "R5 status unchanged");
        chk_bank(2, "R5 bank2 empty");

        // R7 interrupt enable
        wr(6'h01, 8'h20);
        rd_chk(6'h01, 8'h20, "R7 enable readback");
        irq_chk(1'b1, "R7 irq no flag+enable");
        wr(6'h01, 8'h80);
        irq_chk(1'b0, "R7 irq asserted");

        // R6 write-1 no effect, write-0 clears
        wr(6'h00, 8'hFF);
        rd_chk(6'h00, status_exp(), "R6 write one keeps");
        wr(6'h00, 8'h7F); m_flag[0] = 1'b0;
        rd_chk(6'h00, status_exp(), "R6 cleared ch0");
        irq_chk(1'b1, "R7 irq released");
        set_time(8'h11, 8'h22, 8'h13, 8'h09, 8'h03, 8'h25);
        pulse(0);
        chk_bank(0, "R6 recapture bank0");
        irq_chk(1'b0, "R7 irq again");

        // R8 read-only stamps, control low bits
        wr(6'h11, 8'hAA);
        rd_chk(6'h11, m_stamp[0][0], "R8 stamp write ignored");
        wr(6'h28, 8'hFF); m_ctrl[3] = 8'hC0;
        rd_chk(6'h28, 8'hC0, "R8 control low bits");

        // R9 held-low input captures once
        set_time(8'h33, 8'h44, 8'h21, 8'h28, 8'h02, 8'h30);
        @(posedge clk); #1; tamper_n[1] = 1'b0;
        repeat (4) @(posedge clk);
        model_event(1);
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        repeat (4) @(posedge clk);
        chk_bank(1, "R9 held low");
        @(posedge clk); #1; tamper_n[1] = 1'b1;
        repeat (4) @(posedge clk);

        // R5 re-enable then accept
        wr(6'h20, 8'h00); m_ctrl[2] = 8'h00;
        pulse(2);
        chk_bank(2, "R5 reenabled bank2");
        rd_chk(6'h00, status_exp(), "R5 status after reenable");

        // R10 unmapped addresses
        rd_chk(6'h05, 8'h00, "R10 hole");
        rd_chk(6'h17, 8'h00, "R10 bank pad");
        rd_chk(6'h3F, 8'h00, "R10 top");

        repeat (4) @(posedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule